// File: doc/BRIEF.md
# Header-Driven Boot Stream Loader

This block copies a boot image out of an on-chip one-time-programmable memory into system memory. The memory is seen as a synchronous byte-wide ROM organised in 16-byte pages. A start strobe names the page where the stream begins. From there the block walks a chain of blocks. Each block opens with a 16-byte header that supplies three things: a destination address, a payload byte count, and a flag that marks the final block. The payload bytes that follow the header go out on a byte-write port to consecutive addresses, starting at the destination.

The reads are confined to a public window whose last page is 0xDF. With the usual start page of 0x40, the stream can use 2560 bytes. A lower start page stretches that to 3072 bytes at page 0x20. Any read that would go past the end of the window stops the load with an error.

After the final block has been copied, the block reports completion. It also presents the value of the entry-vector register as the address where execution is to begin.

Top module: `otp_boot_loader`

## Requirements
- R1: A `start` pulse seen while the block is not busy makes the first ROM read, in the next cycle, at byte address `{start_page, 4'h0}`. The reads that follow use consecutive byte addresses, one byte per `rom_rd`, and `rom_data` is taken one cycle after `rom_rd`.
- R2: A header is 16 bytes, little-endian. Bytes 4 to 7 give the destination address and bytes 8 to 11 give the payload byte count. Bit 7 of byte 1 (flag bit 15) set means this is the final block. All other header bits, including bytes 12 to 15, have no effect.
- R3: Payload byte k of a block is written once, with `wr_en`=1, `wr_addr` = destination + k and `wr_data` = that byte. The writes come in stream order. The first write comes 35 cycles after the edge that takes `start`.
- R4: Once the final block is finished, `done`=1, `busy`=0 and `jump_addr` = `entry_vec`. These hold until the next start. `done` and `error` are never both high.
- R5: Any of the following sets `error`=1 and `busy`=0 with no ROM read issued: a read at a byte address above 0xDFF, or a start with `start_page` above 0xDF. After that, no read or write takes place until the next start. A stream ending exactly at 0xDFF completes normally.
- R6: A block with a count of zero writes nothing. If that block is not the final one, the next header is read straight after it. If it is the final one, the load completes.
- R7: After reset, `busy`, `done`, `error`, `rom_rd` and `wr_en` are all 0.
- R8: A `start` pulse while `busy`=1 is ignored, and the running load continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a load |
| start_page | input | 8 | Page where the stream begins |
| entry_vec | input | 32 | Entry-vector register value |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | 12 | ROM byte address |
| rom_data | input | 8 | ROM byte, valid one cycle after rom_rd |
| wr_en | output | 1 | Payload byte write strobe |
| wr_addr | output | 32 | Payload byte destination |
| wr_data | output | 8 | Payload byte |
| busy | output | 1 | Load in progress |
| done | output | 1 | Final block loaded |
| error | output | 1 | Window overrun or bad start page |
| jump_addr | output | 32 | Execution start address once done |

## Verification
Every ROM byte takes two cycles: one to issue the read and one to capture the data. A header therefore costs 32 cycles, and one more cycle evaluates it. The first write lands in the 35th cycle after the edge that takes `start`. The status flags change one cycle after the last write or after the refused read.

The bench watches the outputs at the falling edge. It records the cycle of the first ROM read and of the first write, relative to the start edge, and compares those cycles with these counts. It waits on `done` or `error` cycle by cycle rather than sampling at a fixed moment. The write log is compared with the byte list the bench built from its own stream.

// File: rtl/otp_boot_pkg.sv
// Shared types and constants for the boot stream loader.
// Assumes a fixed 16-byte little-endian header with 32-bit fields.
package otp_boot_pkg;
    localparam int WORD_W    = 32;
    localparam int HDR_BYTES = 16;
    localparam int DEST_OFS  = 4;
    localparam int CNT_OFS   = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HREQ, ST_HCAP, ST_EVAL,
        ST_PREQ, ST_PCAP, ST_DONE, ST_FAIL
    } boot_st_e;

    typedef struct packed {
        logic              last;
        logic [WORD_W-1:0] dest;
        logic [WORD_W-1:0] count;
    } blk_hdr_t;
endpackage

// File: rtl/otp_rd_ptr.sv
// ROM byte pointer with public-window bound.
// Loads page*PAGE_BYTES on request, steps by one per read, and flags
// when the next read would fall beyond the last public page.
module otp_rd_ptr #(
    parameter int PAGE_IDX_W = 8,
    parameter int PAGE_BYTES = 16,
    parameter int LAST_PAGE  = 'hDF
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     load,
    input  logic [PAGE_IDX_W-1:0]                    load_page,
    input  logic                                     step,
    output logic [PAGE_IDX_W+$clog2(PAGE_BYTES)-1:0] rom_addr,
    output logic                                     past_end,
    output logic                                     page_bad
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int ROM_AW = PAGE_IDX_W + OFS_W;
    localparam int PW     = ROM_AW + 1;
    localparam int LIMIT  = (LAST_PAGE + 1) * PAGE_BYTES - 1;

    logic [PW-1:0] ptr_q;

    // Pointer register: load at start, advance per issued read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (load)
            ptr_q <= {1'b0, load_page, {OFS_W{1'b0}}};
        else if (step)
            ptr_q <= ptr_q + 1'b1;
    end

    assign rom_addr = ptr_q[ROM_AW-1:0];
    assign past_end = (ptr_q > PW'(LIMIT));
    assign page_bad = (load_page > PAGE_IDX_W'(LAST_PAGE));

    AST_RD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (ptr_q <= PW'(LIMIT)));  // R5
endmodule

// File: rtl/otp_hdr_collect.sv
// Header field collector.
// Counts incoming header bytes and latches the destination, count and
// final flag from their fixed little-endian byte lanes; other bytes
// are dropped. Assumes bytes arrive in stream order after each clear.
module otp_hdr_collect
    import otp_boot_pkg::*;
#(
    parameter int FLAG_BIT = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       cap,
    input  logic [7:0] byte_in,
    output blk_hdr_t   hdr,
    output logic       last_byte
);
    localparam int IDX_W    = $clog2(HDR_BYTES);
    localparam int FLAG_BYT = FLAG_BIT / 8;
    localparam int FLAG_POS = FLAG_BIT % 8;
    localparam int LANES    = WORD_W / 8;

    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] dest_q;
    logic [WORD_W-1:0] cnt_q;
    logic              last_q;

    // Byte index within the current header.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            idx_q <= '0;
        else if (cap)
            idx_q <= idx_q + 1'b1;
    end

    // Final flag latched from its byte lane.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= 1'b0;
        else if (cap && idx_q == IDX_W'(FLAG_BYT))
            last_q <= byte_in[FLAG_POS];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Destination byte lane g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dest_q[8*g +: 8] <= '0;
            else if (cap && idx_q == IDX_W'(DEST_OFS + g))
                dest_q[8*g +: 8] <= byte_in;
        end
        // Count byte lane g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[8*g +: 8] <= '0;
            else if (cap && idx_q == IDX_W'(CNT_OFS + g))
                cnt_q[8*g +: 8] <= byte_in;
        end
    end

    assign last_byte  = (idx_q == IDX_W'(HDR_BYTES - 1));
    assign hdr.last   = last_q;
    assign hdr.dest   = dest_q;
    assign hdr.count  = cnt_q;

    AST_HDR_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (idx_q == '0));  // R2
endmodule

// File: rtl/otp_boot_seq.sv
// Load sequencer.
// Walks header and payload bytes two cycles each (read, capture),
// drives the byte-write port, and stops in done or fail.
// Assumes a one-cycle ROM read latency.
module otp_boot_seq
    import otp_boot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              page_bad,
    input  logic              past_end,
    input  blk_hdr_t          hdr,
    input  logic              hdr_full,
    input  logic [WORD_W-1:0] entry_vec,
    input  logic [7:0]        rom_data,
    output logic              ptr_load,
    output logic              ptr_step,
    output logic              hdr_clr,
    output logic              hdr_cap,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [WORD_W-1:0] jump_addr
);
    boot_st_e          st_q, st_d;
    logic [WORD_W-1:0] remain_q;
    logic [WORD_W-1:0] waddr_q;
    logic              fin_q;
    logic [WORD_W-1:0] jump_q;
    logic              idle_like;

    assign idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_FAIL);

    // Next-state and control strobes.
    always_comb begin
        st_d     = st_q;
        ptr_load = 1'b0;
        ptr_step = 1'b0;
        hdr_clr  = 1'b0;
        hdr_cap  = 1'b0;
        wr_en    = 1'b0;
        case (st_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    ptr_load = 1'b1;
                    hdr_clr  = 1'b1;
                    st_d     = page_bad ? ST_FAIL : ST_HREQ;
                end
            end
            ST_HREQ: begin
                ptr_step = !past_end;
                st_d     = past_end ? ST_FAIL : ST_HCAP;
            end
            ST_HCAP: begin
                hdr_cap = 1'b1;
                st_d    = hdr_full ? ST_EVAL : ST_HREQ;
            end
            ST_EVAL: begin
                hdr_clr = 1'b1;
                if (hdr.count == '0)
                    st_d = hdr.last ? ST_DONE : ST_HREQ;
                else
                    st_d = ST_PREQ;
            end
            ST_PREQ: begin
                ptr_step = !past_end;
                st_d     = past_end ? ST_FAIL : ST_PCAP;
            end
            ST_PCAP: begin
                wr_en = 1'b1;
                if (remain_q == WORD_W'(1))
                    st_d = fin_q ? ST_DONE : ST_HREQ;
                else
                    st_d = ST_PREQ;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Block bookkeeping: destination, remaining count, final flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            waddr_q  <= '0;
            fin_q    <= 1'b0;
        end else if (st_q == ST_EVAL) begin
            remain_q <= hdr.count;
            waddr_q  <= hdr.dest;
            fin_q    <= hdr.last;
        end else if (st_q == ST_PCAP) begin
            remain_q <= remain_q - 1'b1;
            waddr_q  <= waddr_q + 1'b1;
        end
    end

    // Jump address captured on entry to done.
    always_ff @(posedge clk) begin
        if (!rst_n)
            jump_q <= '0;
        else if (st_d == ST_DONE && st_q != ST_DONE)
            jump_q <= entry_vec;
    end

    assign wr_addr   = waddr_q;
    assign wr_data   = rom_data;
    assign busy      = !idle_like;
    assign done      = (st_q == ST_DONE);
    assign error     = (st_q == ST_FAIL);
    assign jump_addr = jump_q;

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));  // R4
    AST_QUIET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> (!ptr_step && !wr_en));  // R5
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(ptr_step));  // R3
    AST_JUMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(jump_addr));  // R4
    AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(wr_en && remain_q == WORD_W'(1) && fin_q)) |=> !done || busy || error);  // R8
endmodule

// File: rtl/otp_boot_loader.sv
// Top level of the boot stream loader.
// Connects the ROM pointer, header collector and sequencer.
// Assumes a synchronous ROM returning rom_data one cycle after rom_rd.
module otp_boot_loader
    import otp_boot_pkg::*;
#(
    parameter int PAGE_IDX_W = 8,
    parameter int PAGE_BYTES = 16,
    parameter int LAST_PAGE  = 'hDF,
    parameter int FLAG_BIT   = 15
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     start,
    input  logic [PAGE_IDX_W-1:0]                    start_page,
    input  logic [WORD_W-1:0]                        entry_vec,
    output logic                                     rom_rd,
    output logic [PAGE_IDX_W+$clog2(PAGE_BYTES)-1:0] rom_addr,
    input  logic [7:0]                               rom_data,
    output logic                                     wr_en,
    output logic [WORD_W-1:0]                        wr_addr,
    output logic [7:0]                               wr_data,
    output logic                                     busy,
    output logic                                     done,
    output logic                                     error,
    output logic [WORD_W-1:0]                        jump_addr
);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    logic     ptr_load, ptr_step, past_end, page_bad;
    logic     hdr_clr, hdr_cap, hdr_full;
    blk_hdr_t hdr;

    otp_rd_ptr #(
        .PAGE_IDX_W (PAGE_IDX_W),
        .PAGE_BYTES (PAGE_BYTES),
        .LAST_PAGE  (LAST_PAGE)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_page (start_page),
        .step      (ptr_step),
        .rom_addr  (rom_addr),
        .past_end  (past_end),
        .page_bad  (page_bad)
    );

    otp_hdr_collect #(
        .FLAG_BIT (FLAG_BIT)
    ) u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (hdr_clr),
        .cap       (hdr_cap),
        .byte_in   (rom_data),
        .hdr       (hdr),
        .last_byte (hdr_full)
    );

    otp_boot_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .page_bad  (page_bad),
        .past_end  (past_end),
        .hdr       (hdr),
        .hdr_full  (hdr_full),
        .entry_vec (entry_vec),
        .rom_data  (rom_data),
        .ptr_load  (ptr_load),
        .ptr_step  (ptr_step),
        .hdr_clr   (hdr_clr),
        .hdr_cap   (hdr_cap),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .done      (done),
        .error     (error),
        .jump_addr (jump_addr)
    );

    assign rom_rd = ptr_step;

    AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rom_rd && rom_addr == {$past(start_page), {OFS_W{1'b0}}}));  // R1
endmodule

// File: tb/otp_boot_loader_test.sv
// Self-checking bench: vector table of streams, then directed cases.
module otp_boot_loader_test;
    typedef struct packed {
        logic [7:0]  page;
        logic [1:0]  nb;
        logic [7:0]  len0;
        logic [7:0]  len1;
        logic [31:0] d0;
        logic [31:0] d1;
        logic [31:0] ev;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{8'h40, 2'd2, 8'd4,  8'd3, 32'h1000_0000, 32'h2000_0100, 32'hFFA0_0000},
        '{8'h20, 2'd1, 8'd10, 8'd0, 32'hFFA0_0000, 32'h0,         32'h0000_1234},
        '{8'h40, 2'd2, 8'd0,  8'd5, 32'h0000_0010, 32'h8000_0000, 32'hCAFE_0000},
        '{8'hDE, 2'd1, 8'd16, 8'd0, 32'h0004_0000, 32'h0,         32'h0BAD_F00D},
        '{8'h40, 2'd1, 8'd0,  8'd0, 32'h5555_0000, 32'h0,         32'h1357_9BDF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  pg = 8'h40;
    logic [31:0] ev = '0;
    logic        rom_rd;
    logic [11:0] rom_addr;
    logic [7:0]  rom_data;
    logic        wr_en;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    logic        busy, done, error;
    logic [31:0] jump_addr;

    logic [7:0]  mem [4096];
    logic [31:0] exp_a [256];
    logic [7:0]  exp_d [256];
    int          exp_n;
    logic [31:0] act_a [256];
    logic [7:0]  act_d [256];
    int          act_n, rd_n;
    int          cyc = 0, t0 = 0, first_rd_t = -1, first_wr_t = -1;
    logic [11:0] first_rd_a;
    int          n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    otp_boot_loader uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_page(pg),
        .entry_vec(ev), .rom_rd(rom_rd), .rom_addr(rom_addr),
        .rom_data(rom_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .done(done), .error(error),
        .jump_addr(jump_addr)
    );

    // Synchronous ROM model.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rom_rd) rom_data <= mem[rom_addr];
    end

    // Port monitor at the falling edge.
    always @(negedge clk) begin
        if (rom_rd) begin
            if (rd_n == 0) begin first_rd_t = cyc - t0; first_rd_a = rom_addr; end
            rd_n++;
        end
        if (wr_en) begin
            if (act_n == 0) first_wr_t = cyc - t0;
            if (act_n < 256) begin act_a[act_n] = wr_addr; act_d[act_n] = wr_data; end
            act_n++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Build a stream in the ROM model and the expected write list.
    task automatic build(input vec_t v);
        int p;
        logic [31:0] d, n;
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        exp_n = 0;
        p = int'(v.page) * 16;
        for (int b = 0; b < int'(v.nb); b++) begin
            d = (b == 0) ? v.d0 : v.d1;
            n = (b == 0) ? 32'(v.len0) : 32'(v.len1);
            mem[p+0] = 8'hA5;
            mem[p+1] = (b == int'(v.nb) - 1) ? 8'hBC : 8'h3C;
            mem[p+2] = 8'h77; mem[p+3] = 8'hEE;
            for (int k = 0; k < 4; k++) begin
                mem[p+4+k]  = d[8*k +: 8];
                mem[p+8+k]  = n[8*k +: 8];
                mem[p+12+k] = 8'h5A ^ 8'(b + k);
            end
            p += 16;
            for (int k = 0; k < int'(n); k++) begin
                if (p < 4096) mem[p] = 8'(int'(v.page) + b * 37 + k * 5 + 1);
                if (exp_n < 256) begin
                    exp_a[exp_n] = d + 32'(k);
                    exp_d[exp_n] = 8'(int'(v.page) + b * 37 + k * 5 + 1);
                end
                exp_n++;
                p++;
            end
        end
    endtask

    task automatic kick(input logic [7:0] page, input logic [31:0] evv);
        @(negedge clk);
        pg = page; ev = evv;
        act_n = 0; rd_n = 0; first_rd_t = -1; first_wr_t = -1;
        start = 1'b1; t0 = cyc;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        int w = 0;
        while (!(done || error) && w < 20000) begin
            @(negedge clk); w++;
        end
    endtask

    task automatic cmp_writes(input int n, input string req);
        bit ok = 1'b1;
        chk(act_n == n, req, "write count", act_n, n);
        for (int i = 0; i < n && i < act_n && i < 256; i++)
            if (act_a[i] !== exp_a[i] || act_d[i] !== exp_d[i]) begin
                if (ok) chk(1'b0, req, "write addr/data", {act_a[i], act_d[i]}, {exp_a[i], exp_d[i]});
                ok = 1'b0;
            end
        if (ok) chk(1'b1, req, "write list", 0, 0);
    endtask

    initial begin
        act_n = 0; rd_n = 0;
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R7: reset state.
        chk(!busy && !done && !error, "R7", "status after reset", {busy, done, error}, 0);
        chk(!rom_rd && !wr_en, "R7", "strobes after reset", {rom_rd, wr_en}, 0);
        rst_n = 1'b1;

        // Vector table walk: R1, R2, R3, R4, R6, boundary of R5.
        for (int vi = 0; vi < NV; vi++) begin
            build(VECS[vi]);
            kick(VECS[vi].page, VECS[vi].ev);
            wait_end();
            chk(done && !error && !busy, "R4", "done flags", {done, error, busy}, 3'b100);
            chk(jump_addr == VECS[vi].ev, "R4", "jump_addr", jump_addr, VECS[vi].ev);
            chk(first_rd_t == 1 && first_rd_a == {VECS[vi].page, 4'h0}, "R1", "first read",
                {first_rd_t, first_rd_a}, {32'd1, VECS[vi].page, 4'h0});
            cmp_writes(exp_n, "R3");
            if (exp_n > 0 && VECS[vi].len0 != 0)
                chk(first_wr_t == 35, "R3", "first write latency", first_wr_t, 35);
            if (VECS[vi].len0 == 0 && VECS[vi].nb == 2)
                chk(first_wr_t == 35 + 33, "R6", "zero block skip latency", first_wr_t, 68);
            if (exp_n == 0)
                chk(act_n == 0 && rd_n == 16, "R6", "final empty block", {act_n, rd_n}, 16);
            chk(rd_n == 16 * int'(VECS[vi].nb) + exp_n, "R2", "read count", rd_n,
                16 * int'(VECS[vi].nb) + exp_n);
        end

        // R4: done holds and jump stays put with entry_vec changing.
        ev = 32'hDEAD_BEEF;
        repeat (5) @(negedge clk);
        chk(done && jump_addr == VECS[NV-1].ev, "R4", "jump held", jump_addr, VECS[NV-1].ev);

        // R5: payload crosses past page 0xDF.
        build('{8'hDE, 2'd1, 8'd17, 8'd0, 32'h0000_0800, 32'h0, 32'h1});
        kick(8'hDE, 32'h1);
        wait_end();
        chk(error && !done && !busy, "R5", "overrun flags", {error, done, busy}, 3'b100);
        cmp_writes(16, "R5");
        chk(rd_n == 32, "R5", "reads before overrun", rd_n, 32);
        repeat (4) @(negedge clk);
        chk(rd_n == 32 && act_n == 16 && error, "R5", "quiet after error", {rd_n, act_n}, {32'd32, 32'd16});

        // R5: header in page 0xDF needs a payload byte beyond it.
        build('{8'hDF, 2'd1, 8'd1, 8'd0, 32'h0, 32'h0, 32'h1});
        kick(8'hDF, 32'h1);
        wait_end();
        chk(error && act_n == 0 && rd_n == 16, "R5", "header at last page", {error, act_n, rd_n}, {1'b1, 32'd0, 32'd16});

        // R5: start page outside the window.
        kick(8'hE0, 32'h1);
        wait_end();
        chk(error && rd_n == 0, "R5", "bad start page", {error, rd_n}, {1'b1, 32'd0});

        // R8: second start while busy is ignored.
        build(VECS[0]);
        kick(VECS[0].page, VECS[0].ev);
        repeat (10) @(negedge clk);
        pg = 8'h20; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end();
        chk(done && !error, "R8", "done after ignored start", {done, error}, 2'b10);
        cmp_writes(exp_n, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule